// File: doc/BRIEF.md
# Requester-Side Odd Byte Parity Generator and Response Checker

This block sits next to the requester of a peripheral bus that carries odd parity. It computes a check bit for every signal group the requester drives: address, merged control, each slave select, enable, write data, strobes, wakeup, and the request and write user sidebands. Wide fields get one check bit per byte lane. Each check bit is the inverse of the XOR of the bits it covers, so payload plus check bit always hold an odd count of ones.

It also checks the check bits the completer returns for ready, read data, slave error, read user and response user. Each group is judged only inside its own validity window. A failure shows as a one-cycle pulse and as a sticky flag for that group. A parameter chooses between generating the check bits in the same cycle and registering them for timing.

Top module: `apb_req_parity`

## Requirements
- R1: Address, write data, request user and write user each get one check bit per byte lane, ceil(width/8) bits. Bit k covers payload bits 8k..8k+7, and lane bits above the field width count as 0. Each check bit equals the inverted XOR of its lane.
- R2: The single control check bit is the inverted XOR of prot[2:0], write and nse. When HAS_PROT=0 or HAS_NSE=0, that input counts as 0, so with both absent the bit equals ~write.
- R3: Each select line, the enable line and the wakeup line has a check bit equal to its inverse, valid in every cycle out of reset including idle. The strobe field (DATA_W/8 bits) has a single check bit equal to its inverted XOR.
- R4: With REG_GEN=0 the check outputs follow the payload inputs in the same cycle. With REG_GEN=1 they show the values for the payload sampled at the previous rising clock edge.
- R5: With REG_GEN=1, every check output reads 1 while reset is asserted, which is the correct value for an all-zero bus.
- R6: The ready group (error bit 0) is in error when any select and enable are high and ready_chk equals ready. Outside that window it never flags.
- R7: The slave-error group (bit 2) and the response-user group (bit 4) are judged only when any select, enable and ready are all high. The group is in error when its payload XORed with its check bit gives 0.
- R8: The read-data group (bit 1, per byte lane) and the read-user group (bit 3) are judged only when any select, enable and ready are high and write is low.
- R9: err_pulse[i] is high for exactly the one cycle after the rising edge at which group i was sampled in error.
- R10: err_sticky[i] is set by an error of group i and holds until reset or until clr_err is sampled high. An error in the same cycle as clr_err leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_err | input | 1 | Clears all sticky error flags |
| addr | input | ADDR_W | Requester address |
| prot | input | 3 | Protection attributes |
| write | input | 1 | Transfer direction, 1 = write |
| nse | input | 1 | Non-secure extension bit |
| sel | input | NSEL | Slave select lines |
| enable | input | 1 | Access-phase enable |
| wdata | input | DATA_W | Write data |
| strb | input | DATA_W/8 | Write strobes |
| wakeup | input | 1 | Wakeup request |
| auser | input | AUSER_W | Request user sideband |
| wuser | input | WUSER_W | Write user sideband |
| addr_chk | output | ceil(ADDR_W/8) | Address check bits |
| ctrl_chk | output | 1 | Merged control check bit |
| sel_chk | output | NSEL | Per-select check bits |
| enable_chk | output | 1 | Enable check bit |
| wdata_chk | output | DATA_W/8 | Write data check bits |
| strb_chk | output | 1 | Strobe check bit |
| wakeup_chk | output | 1 | Wakeup check bit |
| auser_chk | output | ceil(AUSER_W/8) | Request user check bits |
| wuser_chk | output | ceil(WUSER_W/8) | Write user check bits |
| ready | input | 1 | Completer ready |
| ready_chk | input | 1 | Ready check bit |
| rdata | input | DATA_W | Read data |
| rdata_chk | input | DATA_W/8 | Read data check bits |
| slverr | input | 1 | Completer error |
| slverr_chk | input | 1 | Slave error check bit |
| ruser | input | RUSER_W | Read user sideband |
| ruser_chk | input | ceil(RUSER_W/8) | Read user check bits |
| buser | input | BUSER_W | Response user sideband |
| buser_chk | input | ceil(BUSER_W/8) | Response user check bits |
| err_pulse | output | 5 | One-cycle error per group (0 ready, 1 rdata, 2 slverr, 3 ruser, 4 buser) |
| err_sticky | output | 5 | Sticky error per group, same bit order |

## Verification
The only state in the block is the optional check-bit register and the pulse and sticky error registers. In registered mode, a wrong capture shows on the check outputs one cycle after the payload changes. A wrong window gate or lane mapping shows on err_pulse one cycle after the faulty sample. A sticky bit that fails to set or hold stays wrong on err_sticky from that edge until the next clear. The bench compares every output against a behavioural model at each clock, and in the middle of each cycle as well, which separates same-cycle generation from registered generation.

// File: rtl/apb_par_pkg.sv
package apb_par_pkg;
  // Response group indices into the error vectors
  localparam int unsigned RSP_N      = 5;
  localparam int unsigned RSP_READY  = 0;
  localparam int unsigned RSP_RDATA  = 1;
  localparam int unsigned RSP_SLVERR = 2;
  localparam int unsigned RSP_RUSER  = 3;
  localparam int unsigned RSP_BUSER  = 4;
endpackage

// File: rtl/apb_par_lanes.sv
// Odd parity per byte lane; the top lane is zero-padded.
module apb_par_lanes #(
  parameter int W = 8,
  localparam int L = (W + 7) / 8
) (
  input  logic [W-1:0] din,
  output logic [L-1:0] chk
);
  localparam int PW = L * 8;
  logic [PW-1:0] padded;

  assign padded = PW'(din);

  for (genvar g = 0; g < L; g++) begin : g_lane
    assign chk[g] = ~(^padded[g*8 +: 8]);
  end
endmodule

// File: rtl/apb_par_stage.sv
// Optional output register for generated check bits.
module apb_par_stage #(
  parameter int W   = 8,
  parameter bit REG = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] r_q;

  // Reset value: check bits of an all-zero bus are all ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= '1;
    else        r_q <= d;
  end

  assign q = REG ? r_q : d;
endmodule

// File: rtl/apb_resp_check.sv
module apb_resp_check
  import apb_par_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RUSER_W = 4,
  parameter int BUSER_W = 4,
  localparam int DL  = (DATA_W + 7) / 8,
  localparam int RUL = (RUSER_W + 7) / 8,
  localparam int BUL = (BUSER_W + 7) / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               sel_any,
  input  logic               enable,
  input  logic               write,
  input  logic               ready,
  input  logic               ready_chk,
  input  logic [DATA_W-1:0]  rdata,
  input  logic [DL-1:0]      rdata_chk,
  input  logic               slverr,
  input  logic               slverr_chk,
  input  logic [RUSER_W-1:0] ruser,
  input  logic [RUL-1:0]     ruser_chk,
  input  logic [BUSER_W-1:0] buser,
  input  logic [BUL-1:0]     buser_chk,
  output logic [RSP_N-1:0]   err_pulse,
  output logic [RSP_N-1:0]   err_sticky
);
  logic [DL-1:0]  rdata_exp;
  logic [RUL-1:0] ruser_exp;
  logic [BUL-1:0] buser_exp;
  logic           win_acc, win_done, win_rd;
  logic [RSP_N-1:0] bad_d, sticky_d, pulse_q, sticky_q;

  apb_par_lanes #(.W(DATA_W))  u_rdata (.din(rdata), .chk(rdata_exp));
  apb_par_lanes #(.W(RUSER_W)) u_ruser (.din(ruser), .chk(ruser_exp));
  apb_par_lanes #(.W(BUSER_W)) u_buser (.din(buser), .chk(buser_exp));

  always_comb begin
    win_acc  = sel_any & enable;
    win_done = win_acc & ready;
    win_rd   = win_done & ~write;
    bad_d             = '0;
    bad_d[RSP_READY]  = win_acc  & (ready_chk == ready);
    bad_d[RSP_RDATA]  = win_rd   & (rdata_chk != rdata_exp);
    bad_d[RSP_SLVERR] = win_done & (slverr_chk == slverr);
    bad_d[RSP_RUSER]  = win_rd   & (ruser_chk != ruser_exp);
    bad_d[RSP_BUSER]  = win_done & (buser_chk != buser_exp);
    sticky_d = (sticky_q & ~{RSP_N{clr}}) | bad_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q  <= '0;
      sticky_q <= '0;
    end else begin
      pulse_q  <= bad_d;
      sticky_q <= sticky_d;
    end
  end

  assign err_pulse  = pulse_q;
  assign err_sticky = sticky_q;

  for (genvar i = 0; i < RSP_N; i++) begin : g_chk
    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[i] && !clr) |=> sticky_q[i]);
    assert_pulse_marks_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q[i] |-> sticky_q[i]);
  end

  assert_ready_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q[RSP_READY] |-> $past(sel_any && enable));
  assert_done_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q[RSP_SLVERR] || pulse_q[RSP_BUSER]) |-> $past(sel_any && enable && ready));
  assert_read_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q[RSP_RDATA] || pulse_q[RSP_RUSER]) |-> $past(sel_any && enable && ready && !write));
endmodule

// File: rtl/apb_req_parity.sv
module apb_req_parity
  import apb_par_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NSEL     = 2,
  parameter int AUSER_W  = 10,
  parameter int WUSER_W  = 8,
  parameter int RUSER_W  = 5,
  parameter int BUSER_W  = 3,
  parameter bit HAS_PROT = 1'b1,
  parameter bit HAS_NSE  = 1'b1,
  parameter bit REG_GEN  = 1'b0,
  localparam int AL     = (ADDR_W + 7) / 8,
  localparam int DL     = (DATA_W + 7) / 8,
  localparam int STRB_W = DATA_W / 8,
  localparam int AUL    = (AUSER_W + 7) / 8,
  localparam int WUL    = (WUSER_W + 7) / 8,
  localparam int RUL    = (RUSER_W + 7) / 8,
  localparam int BUL    = (BUSER_W + 7) / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_err,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2:0]         prot,
  input  logic               write,
  input  logic               nse,
  input  logic [NSEL-1:0]    sel,
  input  logic               enable,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [STRB_W-1:0]  strb,
  input  logic               wakeup,
  input  logic [AUSER_W-1:0] auser,
  input  logic [WUSER_W-1:0] wuser,
  output logic [AL-1:0]      addr_chk,
  output logic               ctrl_chk,
  output logic [NSEL-1:0]    sel_chk,
  output logic               enable_chk,
  output logic [DL-1:0]      wdata_chk,
  output logic               strb_chk,
  output logic               wakeup_chk,
  output logic [AUL-1:0]     auser_chk,
  output logic [WUL-1:0]     wuser_chk,
  input  logic               ready,
  input  logic               ready_chk,
  input  logic [DATA_W-1:0]  rdata,
  input  logic [DL-1:0]      rdata_chk,
  input  logic               slverr,
  input  logic               slverr_chk,
  input  logic [RUSER_W-1:0] ruser,
  input  logic [RUL-1:0]     ruser_chk,
  input  logic [BUSER_W-1:0] buser,
  input  logic [BUL-1:0]     buser_chk,
  output logic [RSP_N-1:0]   err_pulse,
  output logic [RSP_N-1:0]   err_sticky
);
  localparam int GEN_W = AL + 1 + NSEL + 1 + DL + 1 + 1 + AUL + WUL;

  logic [AL-1:0]    addr_c;
  logic [DL-1:0]    wdata_c;
  logic [AUL-1:0]   auser_c;
  logic [WUL-1:0]   wuser_c;
  logic             ctrl_c, strb_c;
  logic [4:0]       ctrl_bits;
  logic [GEN_W-1:0] gen_d, gen_q;
  logic             primed;

  // Absent control fields are forced low before the merged parity
  assign ctrl_bits = {(HAS_NSE ? nse : 1'b0), write, (HAS_PROT ? prot : 3'b000)};

  apb_par_lanes #(.W(ADDR_W))  u_addr  (.din(addr),      .chk(addr_c));
  apb_par_lanes #(.W(DATA_W))  u_wdata (.din(wdata),     .chk(wdata_c));
  apb_par_lanes #(.W(AUSER_W)) u_auser (.din(auser),     .chk(auser_c));
  apb_par_lanes #(.W(WUSER_W)) u_wuser (.din(wuser),     .chk(wuser_c));
  apb_par_lanes #(.W(5))       u_ctrl  (.din(ctrl_bits), .chk(ctrl_c));
  apb_par_lanes #(.W(STRB_W))  u_strb  (.din(strb),      .chk(strb_c));

  assign gen_d = {wuser_c, auser_c, ~wakeup, strb_c, wdata_c, ~enable, ~sel, ctrl_c, addr_c};

  apb_par_stage #(.W(GEN_W), .REG(REG_GEN)) u_stage (
    .clk(clk), .rst_n(rst_n), .d(gen_d), .q(gen_q));

  assign {wuser_chk, auser_chk, wakeup_chk, strb_chk, wdata_chk,
          enable_chk, sel_chk, ctrl_chk, addr_chk} = gen_q;

  apb_resp_check #(.DATA_W(DATA_W), .RUSER_W(RUSER_W), .BUSER_W(BUSER_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .clr(clr_err),
    .sel_any(|sel), .enable(enable), .write(write), .ready(ready),
    .ready_chk(ready_chk), .rdata(rdata), .rdata_chk(rdata_chk),
    .slverr(slverr), .slverr_chk(slverr_chk),
    .ruser(ruser), .ruser_chk(ruser_chk), .buser(buser), .buser_chk(buser_chk),
    .err_pulse(err_pulse), .err_sticky(err_sticky));

  // Marks that at least one edge has been taken out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  if (REG_GEN) begin : g_reg_chk
    assert_reg_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (sel_chk == ~$past(sel)) && (wakeup_chk == ~$past(wakeup)));
  end else begin : g_comb_chk
    assert_same_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (enable_chk != enable) && (sel_chk == ~sel));
  end
endmodule

// File: tb/apb_req_parity_bench.sv
module apb_req_parity_bench;
  localparam int AW = 32, DW = 32, NS = 2, AUW = 10, WUW = 8, RUW = 5, BUW = 3;
  localparam int SW = DW / 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, clr_err, write, nse, enable, wakeup, ready, ready_chk, slverr, slverr_chk;
  logic [AW-1:0] addr; logic [2:0] prot; logic [NS-1:0] sel;
  logic [DW-1:0] wdata, rdata; logic [SW-1:0] strb;
  logic [AUW-1:0] auser; logic [WUW-1:0] wuser; logic [RUW-1:0] ruser; logic [BUW-1:0] buser;
  logic [3:0] rdata_chk; logic ruser_chk, buser_chk;

  logic [3:0] a_addr_chk, a_wdata_chk, b_addr_chk, b_wdata_chk;
  logic a_ctrl, a_en, a_strb, a_wake, b_ctrl, b_en, b_strb, b_wake;
  logic [NS-1:0] a_sel, b_sel; logic [1:0] a_auser, b_auser; logic a_wuser, b_wuser;
  logic [4:0] a_pulse, a_sticky, b_pulse, b_sticky;

  int checks = 0, failures = 0;
  bit done = 0;

  apb_req_parity u_apb_req_parity (
    .clk, .rst_n, .clr_err, .addr, .prot, .write, .nse, .sel, .enable, .wdata, .strb,
    .wakeup, .auser, .wuser,
    .addr_chk(a_addr_chk), .ctrl_chk(a_ctrl), .sel_chk(a_sel), .enable_chk(a_en),
    .wdata_chk(a_wdata_chk), .strb_chk(a_strb), .wakeup_chk(a_wake),
    .auser_chk(a_auser), .wuser_chk(a_wuser),
    .ready, .ready_chk, .rdata, .rdata_chk, .slverr, .slverr_chk,
    .ruser, .ruser_chk, .buser, .buser_chk, .err_pulse(a_pulse), .err_sticky(a_sticky));

  apb_req_parity #(.REG_GEN(1'b1), .HAS_PROT(1'b0), .HAS_NSE(1'b0)) u_apb_req_parity_reg (
    .clk, .rst_n, .clr_err, .addr, .prot, .write, .nse, .sel, .enable, .wdata, .strb,
    .wakeup, .auser, .wuser,
    .addr_chk(b_addr_chk), .ctrl_chk(b_ctrl), .sel_chk(b_sel), .enable_chk(b_en),
    .wdata_chk(b_wdata_chk), .strb_chk(b_strb), .wakeup_chk(b_wake),
    .auser_chk(b_auser), .wuser_chk(b_wuser),
    .ready, .ready_chk, .rdata, .rdata_chk, .slverr, .slverr_chk,
    .ruser, .ruser_chk, .buser, .buser_chk, .err_pulse(b_pulse), .err_sticky(b_sticky));

  // Behavioural reference: count ones per lane, odd parity -> check 1 when count even
  function automatic logic [7:0] ref_chk(input logic [63:0] v, input int w);
    logic [7:0] res = '0;
    for (int l = 0; l < (w + 7) / 8; l++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) if (l*8 + b < w && v[l*8 + b]) ones++;
      res[l] = (ones % 2 == 0);
    end
    return res;
  endfunction

  // Layout: {wuser,auser[1:0],wake,strb,wdata[3:0],en,sel[1:0],ctrl,addr[3:0]}
  function automatic logic [16:0] exp_gen(input bit has_ctl);
    logic [7:0] c;
    int ones;
    ones = $countones(write) + (has_ctl ? $countones(prot) + $countones(nse) : 0);
    c = ref_chk(64'(auser), AUW);
    return {ref_chk(64'(wuser), WUW)[0], c[1:0], ~wakeup, ref_chk(64'(strb), SW)[0],
            ref_chk(64'(wdata), DW)[3:0], ~enable, ~sel, (ones % 2 == 0), ref_chk(64'(addr), AW)[3:0]};
  endfunction

  function automatic logic [4:0] exp_bad();
    logic [4:0] e = '0;
    bit acc = (sel != 0) && enable;
    bit dn  = acc && ready;
    bit rd  = dn && !write;
    e[0] = acc && (ready_chk == ready);
    e[1] = rd && (rdata_chk != ref_chk(64'(rdata), DW)[3:0]);
    e[2] = dn && (slverr_chk == slverr);
    e[3] = rd && (ruser_chk != ref_chk(64'(ruser), RUW)[0]);
    e[4] = dn && (buser_chk != ref_chk(64'(buser), BUW)[0]);
    return e;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_gen(input string who, input logic [16:0] act, input logic [16:0] exp);
    check({who, " R1 lane bits"}, {act[16:14], act[11:8], act[3:0]}, {exp[16:14], exp[11:8], exp[3:0]});
    check({who, " R2 ctrl bit"}, act[4], exp[4]);
    check({who, " R3 single bits"}, {act[13:12], act[7:5]}, {exp[13:12], exp[7:5]});
  endtask

  function automatic logic [16:0] act_a();
    return {a_wuser, a_auser, a_wake, a_strb, a_wdata_chk, a_en, a_sel, a_ctrl, a_addr_chk};
  endfunction
  function automatic logic [16:0] act_b();
    return {b_wuser, b_auser, b_wake, b_strb, b_wdata_chk, b_en, b_sel, b_ctrl, b_addr_chk};
  endfunction

  task automatic drive_random();
    addr = $urandom; prot = 3'($urandom); nse = 1'($urandom); write = 1'($urandom);
    case ($urandom_range(0, 3)) 0: sel = '0; 1: sel = 2'b01; 2: sel = 2'b10; default: sel = 2'b11; endcase
    enable = 1'($urandom); ready = 1'($urandom); slverr = 1'($urandom);
    wdata = $urandom; strb = 4'($urandom); wakeup = 1'($urandom);
    auser = 10'($urandom); wuser = 8'($urandom); rdata = $urandom;
    ruser = 5'($urandom); buser = 3'($urandom);
    ready_chk  = ~ready  ^ ($urandom_range(0, 3) == 0);
    slverr_chk = ~slverr ^ ($urandom_range(0, 3) == 0);
    rdata_chk  = ref_chk(64'(rdata), DW)[3:0] ^ (($urandom_range(0, 3) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'h0);
    ruser_chk  = ref_chk(64'(ruser), RUW)[0] ^ ($urandom_range(0, 3) == 0);
    buser_chk  = ref_chk(64'(buser), BUW)[0] ^ ($urandom_range(0, 3) == 0);
    clr_err    = ($urandom_range(0, 15) == 0);
  endtask

  logic [4:0] m_sticky, bad;
  logic [16:0] prev_b;

  initial begin
    rst_n = 0; clr_err = 0; addr = '0; prot = '0; write = 0; nse = 0; sel = '0; enable = 0;
    wdata = '0; strb = '0; wakeup = 0; auser = '0; wuser = '0; ready = 0; ready_chk = 0;
    rdata = '0; rdata_chk = '0; slverr = 0; slverr_chk = 0; ruser = '0; ruser_chk = 0;
    buser = '0; buser_chk = 0;
    repeat (3) @(negedge clk);
    check("R5 registered checks in reset", 64'(act_b()), 64'h1FFFF);
    check("R10 sticky clear in reset", {a_sticky, b_sticky}, '0);
    check("R9 pulse clear in reset", {a_pulse, b_pulse}, '0);
    // Hold reset values across a clock with non-zero payload
    addr = 32'h0000_0001;
    @(posedge clk); #1;
    check("R5 registered checks hold in reset", 64'(act_b()), 64'h1FFFF);
    @(negedge clk);
    addr = '0;
    rst_n = 1;
    m_sticky = '0;
    for (int n = 0; n < 800; n++) begin
      @(negedge clk);
      bad = exp_bad();
      m_sticky = (m_sticky & ~{5{clr_err}}) | bad;
      check("R6 ready pulse", a_pulse[0], bad[0]);
      check("R8 read pulses", {a_pulse[3], a_pulse[1]}, {bad[3], bad[1]});
      check("R7 completion pulses", {a_pulse[4], a_pulse[2]}, {bad[4], bad[2]});
      check("R9 pulse vector reg instance", b_pulse, bad);
      check("R10 sticky", {a_sticky, b_sticky}, {m_sticky, m_sticky});
      check_gen("comb", act_a(), exp_gen(1));
      check_gen("reg", act_b(), exp_gen(0));
      prev_b = exp_gen(0);
      drive_random();
      #1;
      check_gen("R4 comb same cycle", act_a(), exp_gen(1));
      check_gen("R4 reg previous edge", act_b(), prev_b);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule